// File: doc/BRIEF.md
# Bit-Serial Associative Word Array

This block is a content-searchable store of `WORDS` words, each `WIDTH` bits wide. Every word has its own one-bit processing element. A search or an add walks the bit positions one slice per cycle, and each slice touches every word at once. A single shared operand register, called the key, supplies the comparand or the addend. A bit-position mask restricts which columns take part. A per-word participation flag decides which words are affected.

A search leaves one match flag per word in a response vector. A read command passes that vector through a lowest-index-first resolver and returns a single word together with its index. If no word matched, it returns a no-hit status. The add command sums the key into the masked columns of every participating word and writes the result back into the word store. Contiguous masked columns form independent fields. Software-visible state is limited to the commands listed below.

Top module: `assoc_bitslice_array`

## Requirements
- R1: Command opcodes on `cmd_op` are 0 idle, 1 store word, 2 load key, 3 load mask, 4 load participation, 5 search, 6 add, 7 read. A command is taken on a rising edge with `cmd_valid` high. Store word writes `cmd_data` into the word at `cmd_addr`.
- R2: A search first sets the match flag of every participating word to 1. It then clears the flag of any word where some masked bit differs from the key. The slices are walked from the top bit down. The final `resp_vec` is visible once `busy` has fallen.
- R3: A column whose mask bit is 0 never causes a mismatch. With a mask of all zeros, every participating word matches.
- R4: A word whose participation bit (bit w of `part_data` as loaded by opcode 4) is 0 keeps its match flag through a search and keeps its contents through an add.
- R5: A read raises `rd_valid` for the cycle after it is taken. `rd_hit` is then 1, and `rd_index`/`rd_word` give the lowest-index word whose match flag is set.
- R6: A read with no match flag set gives `rd_hit` = 0, `rd_index` = 0 and `rd_word` = 0.
- R7: An add sums the key into the masked columns of each participating word, from the least significant bit upward. It keeps one carry per word, cleared at start, and the carry out of the top of a field is dropped.
- R8: `busy` is high for exactly `WIDTH` cycles after a search or add is taken.
- R9: Any command presented while `busy` is high has no effect, including store word and read.
- R10: During an add, a column with mask bit 0 is left unchanged and clears the carry, so separate masked fields add independently.
- R11: After reset, the word store and the match flags are 0, every word participates, the mask is all ones, the key is 0 and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | $clog2(WORDS) | Word index for store word |
| cmd_data | input | WIDTH | Word, key or mask value |
| part_data | input | WORDS | Participation flags for opcode 4 |
| busy | output | 1 | Bit-slice operation in progress |
| resp_vec | output | WORDS | Per-word match flags |
| rd_valid | output | 1 | Read result strobe |
| rd_hit | output | 1 | Some word matched |
| rd_index | output | $clog2(WORDS) | Index of the selected word |
| rd_word | output | WIDTH | Contents of the selected word |

## Verification
Several corner cases are targeted.

- Masked-off columns are checked. A design that compared them would drop matches under a zero mask.
- Non-participating words are checked. A design that cleared their flags would make a read return a different index.
- Adds that overflow are checked. An add that kept the carry across an unmasked column would corrupt the upper field, and one that kept the carry beyond the word width would disturb the wraparound result.
- Commands issued mid-operation are checked. A design that accepted them would overwrite a word or emit a stray read strobe.
- The resolver's choice among several matches is checked. A resolver that picked the highest responder would return the wrong index.

// File: rtl/assoc_pkg.sv
package assoc_pkg;
   typedef enum logic [2:0] {
      OP_IDLE  = 3'd0,
      OP_STORE = 3'd1,
      OP_KEY   = 3'd2,
      OP_MASK  = 3'd3,
      OP_PART  = 3'd4,
      OP_SRCH  = 3'd5,
      OP_ADD   = 3'd6,
      OP_READ  = 3'd7
   } assoc_op_e;
endpackage

// File: rtl/assoc_slice_seq.sv
// Bit-slice sequencer: holds busy for WIDTH cycles and produces the column index.
module assoc_slice_seq #(
   parameter int WIDTH = 8,
   localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_srch,
   input  logic          start_add,
   output logic          busy,
   output logic          add_mode,
   output logic [BW-1:0] col
);
   localparam logic [BW-1:0] LAST = BW'(WIDTH - 1);

   logic [BW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         add_mode <= 1'b0;
         cnt      <= '0;
      end else if (!busy) begin
         if (start_srch || start_add) begin
            busy     <= 1'b1;
            add_mode <= start_add;
            cnt      <= '0;
         end
      end else if (cnt == LAST) begin
         busy <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // add walks upward from bit 0, search walks downward from the top bit
   assign col = add_mode ? cnt : (LAST - cnt);
endmodule

// File: rtl/assoc_word_pe.sv
// One word of storage with its one-bit processing element.
module assoc_word_pe #(
   parameter int WIDTH = 8,
   localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             store,
   input  logic [WIDTH-1:0] store_data,
   input  logic             part,
   input  logic             srch_init,
   input  logic             srch_step,
   input  logic             add_init,
   input  logic             add_step,
   input  logic [BW-1:0]    col,
   input  logic             key_bit,
   input  logic             mask_bit,
   output logic [WIDTH-1:0] word_o,
   output logic             match_o
);
   logic [WIDTH-1:0] mem;
   logic             match;
   logic             carry;
   logic             cur;
   logic             same;
   logic             sum;
   logic             cout;

   always_comb begin
      cur  = mem[col];
      same = ~(cur ^ key_bit);
      sum  = cur ^ key_bit ^ carry;
      cout = (cur & key_bit) | (cur & carry) | (key_bit & carry);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem   <= '0;
         match <= 1'b0;
         carry <= 1'b0;
      end else begin
         if (store) mem <= store_data;
         if (part) begin
            if (srch_init) match <= 1'b1;
            if (srch_step) match <= match & (~mask_bit | same);
            if (add_init)  carry <= 1'b0;
            if (add_step) begin
               if (mask_bit) begin
                  mem[col] <= sum;
                  carry    <= cout;
               end else begin
                  carry    <= 1'b0;
               end
            end
         end
      end
   end

   assign word_o  = mem;
   assign match_o = match;
endmodule

// File: rtl/assoc_resolver.sv
// Lowest-index-first multiple-match resolver.
module assoc_resolver #(
   parameter int WORDS = 8,
   localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input  logic [WORDS-1:0] req,
   output logic             any,
   output logic [IW-1:0]    idx
);
   always_comb begin
      any = |req;
      idx = '0;
      for (int i = WORDS - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/assoc_bitslice_array.sv
module assoc_bitslice_array
   import assoc_pkg::*;
#(
   parameter int WORDS = 8,
   parameter int WIDTH = 8,
   localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1,
   localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_op,
   input  logic [IW-1:0]    cmd_addr,
   input  logic [WIDTH-1:0] cmd_data,
   input  logic [WORDS-1:0] part_data,
   output logic             busy,
   output logic [WORDS-1:0] resp_vec,
   output logic             rd_valid,
   output logic             rd_hit,
   output logic [IW-1:0]    rd_index,
   output logic [WIDTH-1:0] rd_word
);
   generate
      if (WORDS < 2) begin : g_bad_words
         $error("WORDS must be at least 2");
      end
      if (WIDTH < 2) begin : g_bad_width
         $error("WIDTH must be at least 2");
      end
   endgenerate

   logic             accept;
   assoc_op_e        op;
   logic [WIDTH-1:0] key_q;
   logic [WIDTH-1:0] mask_q;
   logic [WORDS-1:0] part_q;
   logic             add_mode;
   logic [BW-1:0]    col;
   logic             srch_init;
   logic             add_init;
   logic             srch_step;
   logic             add_step;
   logic [WIDTH-1:0] word_arr [WORDS];
   logic             sel_any;
   logic [IW-1:0]    sel_idx;

   assign op        = assoc_op_e'(cmd_op);
   assign accept    = cmd_valid & ~busy;
   assign srch_init = accept && (op == OP_SRCH);
   assign add_init  = accept && (op == OP_ADD);
   assign srch_step = busy & ~add_mode;
   assign add_step  = busy & add_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q  <= '0;
         mask_q <= '1;
         part_q <= '1;
      end else if (accept) begin
         if (op == OP_KEY)  key_q  <= cmd_data;
         if (op == OP_MASK) mask_q <= cmd_data;
         if (op == OP_PART) part_q <= part_data;
      end
   end

   assoc_slice_seq #(.WIDTH(WIDTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_srch(srch_init),
      .start_add (add_init),
      .busy      (busy),
      .add_mode  (add_mode),
      .col       (col)
   );

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_pe
         logic store_w;
         assign store_w = accept && (op == OP_STORE) && (cmd_addr == IW'(w));
         assoc_word_pe #(.WIDTH(WIDTH)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .store     (store_w),
            .store_data(cmd_data),
            .part      (part_q[w]),
            .srch_init (srch_init),
            .srch_step (srch_step),
            .add_init  (add_init),
            .add_step  (add_step),
            .col       (col),
            .key_bit   (key_q[col]),
            .mask_bit  (mask_q[col]),
            .word_o    (word_arr[w]),
            .match_o   (resp_vec[w])
         );
      end
   endgenerate

   assoc_resolver #(.WORDS(WORDS)) u_res (
      .req(resp_vec),
      .any(sel_any),
      .idx(sel_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_hit   <= 1'b0;
         rd_index <= '0;
         rd_word  <= '0;
      end else begin
         rd_valid <= accept && (op == OP_READ);
         if (accept && (op == OP_READ)) begin
            rd_hit   <= sel_any;
            rd_index <= sel_any ? sel_idx : '0;
            rd_word  <= sel_any ? word_arr[sel_idx] : '0;
         end
      end
   end
endmodule

// File: rtl/assoc_checker.sv
module assoc_checker #(
   parameter int WORDS = 8,
   parameter int WIDTH = 8,
   localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [2:0]       cmd_op,
   input logic             busy,
   input logic [WORDS-1:0] resp_vec,
   input logic [WORDS-1:0] part_q,
   input logic             rd_valid,
   input logic             rd_hit,
   input logic [IW-1:0]    rd_index,
   input logic [WIDTH-1:0] rd_word
);
   int unsigned      run;
   logic [WORDS-1:0] below;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run <= 0;
      else if (busy) run <= run + 1;
      else run <= 0;
   end

   always_comb begin
      below = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (i < int'(rd_index)) below[i] = 1'b1;
      end
   end

   a_r8_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run < WIDTH));
   a_r8_busy_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && run != 0) |-> (run == WIDTH));
   a_r5_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_hit) |-> (resp_vec[rd_index] && ((resp_vec & below) == '0)));
   a_r6_nohit: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_hit) |-> (resp_vec == '0 && rd_word == '0 && rd_index == '0));
   a_r4_part_hold: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((resp_vec ^ $past(resp_vec)) & ~$past(part_q)) == '0));
   a_r2_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ((resp_vec & ~$past(resp_vec)) == '0));
   a_r9_read_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(cmd_valid && cmd_op == 3'd7 && !busy));
endmodule

bind assoc_bitslice_array assoc_checker #(.WORDS(WORDS), .WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_op   (cmd_op),
   .busy     (busy),
   .resp_vec (resp_vec),
   .part_q   (part_q),
   .rd_valid (rd_valid),
   .rd_hit   (rd_hit),
   .rd_index (rd_index),
   .rd_word  (rd_word)
);

// File: tb/assoc_bitslice_array_test.sv
module assoc_bitslice_array_test;
   import assoc_pkg::*;

   localparam int WORDS = 8;
   localparam int WIDTH = 8;
   localparam int IW = 3;

   typedef struct packed {
      logic [2:0] op;
      logic [2:0] a;
      logic [7:0] d;
      logic       chk;
      logic [3:0] rq;
      logic [7:0] e1;   // search: expected resp_vec; read: {hit,0000,index}
      logic [7:0] e2;   // read: expected word
   } vec_t;

   localparam int NV = 49;
   localparam vec_t TAB [NV] = '{
      // R1 store the word set
      '{3'd1, 3'd0, 8'h3C, 1'b0, 4'd1, 8'h00, 8'h00},
      '{3'd1, 3'd1, 8'hA5, 1'b0, 4'd1, 8'h00, 8'h00},
      '{3'd1, 3'd2, 8'h3F, 1'b0, 4'd1, 8'h00, 8'h00},
      '{3'd1, 3'd3, 8'h5A, 1'b0, 4'd1, 8'h00, 8'h00},
      '{3'd1, 3'd4, 8'h3C, 1'b0, 4'd1, 8'h00, 8'h00},
      '{3'd1, 3'd5, 8'hFF, 1'b0, 4'd1, 8'h00, 8'h00},
      '{3'd1, 3'd6, 8'h00, 1'b0, 4'd1, 8'h00, 8'h00},
      '{3'd1, 3'd7, 8'h3C, 1'b0, 4'd1, 8'h00, 8'h00},
      // R2 exact search, then R5 lowest of three responders
      '{3'd2, 3'd0, 8'h3C, 1'b0, 4'd2, 8'h00, 8'h00},
      '{3'd3, 3'd0, 8'hFF, 1'b0, 4'd2, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd2, 8'h91, 8'h00},
      '{3'd7, 3'd0, 8'h00, 1'b1, 4'd5, 8'h80, 8'h3C},
      // R3 upper-nibble search
      '{3'd3, 3'd0, 8'hF0, 1'b0, 4'd3, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd3, 8'h95, 8'h00},
      // R4 word 0 left out keeps its flag
      '{3'd4, 3'd0, 8'hFE, 1'b0, 4'd4, 8'h00, 8'h00},
      '{3'd2, 3'd0, 8'hA0, 1'b0, 4'd4, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd4, 8'h03, 8'h00},
      '{3'd7, 3'd0, 8'h00, 1'b1, 4'd4, 8'h80, 8'h3C},
      // R3 zero mask: everybody matches
      '{3'd4, 3'd0, 8'hFF, 1'b0, 4'd3, 8'h00, 8'h00},
      '{3'd3, 3'd0, 8'h00, 1'b0, 4'd3, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd3, 8'hFF, 8'h00},
      // R6 no responder
      '{3'd3, 3'd0, 8'hFF, 1'b0, 4'd6, 8'h00, 8'h00},
      '{3'd2, 3'd0, 8'h77, 1'b0, 4'd6, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd2, 8'h00, 8'h00},
      '{3'd7, 3'd0, 8'h00, 1'b1, 4'd6, 8'h00, 8'h00},
      // R7 add 1 to words 5 (FF wraps to 00) and 6
      '{3'd2, 3'd0, 8'h01, 1'b0, 4'd7, 8'h00, 8'h00},
      '{3'd4, 3'd0, 8'h60, 1'b0, 4'd7, 8'h00, 8'h00},
      '{3'd6, 3'd0, 8'h00, 1'b0, 4'd7, 8'h00, 8'h00},
      '{3'd2, 3'd0, 8'h00, 1'b0, 4'd7, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd7, 8'h20, 8'h00},
      '{3'd7, 3'd0, 8'h00, 1'b1, 4'd7, 8'h85, 8'h00},
      // R10 low-nibble field add on word 3: 5A -> 52
      '{3'd4, 3'd0, 8'h08, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd3, 3'd0, 8'h0F, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd2, 3'd0, 8'h18, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd6, 3'd0, 8'h00, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd4, 3'd0, 8'hFF, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd3, 3'd0, 8'hFF, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd2, 3'd0, 8'h52, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd10, 8'h08, 8'h00},
      '{3'd7, 3'd0, 8'h00, 1'b1, 4'd10, 8'h83, 8'h52},
      // R10 two fields on word 7: 3C -> 78
      '{3'd4, 3'd0, 8'h80, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd3, 3'd0, 8'hCF, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd2, 3'd0, 8'h4C, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd6, 3'd0, 8'h00, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd4, 3'd0, 8'hFF, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd3, 3'd0, 8'hFF, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd2, 3'd0, 8'h78, 1'b0, 4'd10, 8'h00, 8'h00},
      '{3'd5, 3'd0, 8'h00, 1'b1, 4'd10, 8'h80, 8'h00},
      '{3'd7, 3'd0, 8'h00, 1'b1, 4'd1, 8'h87, 8'h78}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [2:0]       cmd_op = 3'd0;
   logic [IW-1:0]    cmd_addr = '0;
   logic [WIDTH-1:0] cmd_data = '0;
   logic [WORDS-1:0] part_data = '0;
   logic             busy;
   logic [WORDS-1:0] resp_vec;
   logic             rd_valid;
   logic             rd_hit;
   logic [IW-1:0]    rd_index;
   logic [WIDTH-1:0] rd_word;

   int nchk = 0;
   int nbad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assoc_bitslice_array #(.WORDS(WORDS), .WIDTH(WIDTH)) uut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .part_data(part_data),
      .busy(busy), .resp_vec(resp_vec), .rd_valid(rd_valid), .rd_hit(rd_hit),
      .rd_index(rd_index), .rd_word(rd_word)
   );

   task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [2:0] a, input logic [7:0] d,
                        output int cycles);
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_addr  = a;
      cmd_data  = d;
      part_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      cmd_op    = 3'd0;
      cycles = 0;
      while (busy) begin
         cycles++;
         @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nchk++;
         nbad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
         $finish;
      end
   end

   initial begin
      int cyc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check("R11 busy", 32'(busy), 32'd0);
      check("R11 resp", 32'(resp_vec), 32'd0);
      check("R11 rd_valid", 32'(rd_valid), 32'd0);
      issue(3'd7, 3'd0, 8'h00, cyc);
      check("R11 read nohit", {rd_valid, rd_hit}, 32'h2);
      // R11 key 0, full mask, all participate: all-zero store matches everywhere
      issue(3'd5, 3'd0, 8'h00, cyc);
      check("R11 search", 32'(resp_vec), 32'hFF);

      for (int i = 0; i < NV; i++) begin
         issue(TAB[i].op, TAB[i].a, TAB[i].d, cyc);
         if (TAB[i].op == 3'd5 || TAB[i].op == 3'd6)
            check("R8 busy length", 32'(cyc), 32'(WIDTH));
         if (TAB[i].chk) begin
            if (TAB[i].op == 3'd7) begin
               check($sformatf("R%0d read valid", TAB[i].rq), 32'(rd_valid), 32'd1);
               check($sformatf("R%0d read hit/index", TAB[i].rq),
                     {24'd0, rd_hit, 4'd0, rd_index}, 32'(TAB[i].e1));
               check($sformatf("R%0d read word", TAB[i].rq), 32'(rd_word), 32'(TAB[i].e2));
            end else begin
               check($sformatf("R%0d response", TAB[i].rq), 32'(resp_vec), 32'(TAB[i].e1));
            end
         end
      end

      // R9 commands during busy are ignored
      issue(3'd2, 3'd0, 8'hA5, cyc);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 3'd5;
      @(negedge clk);
      check("R9 busy started", 32'(busy), 32'd1);
      cmd_op = 3'd1; cmd_addr = 3'd1; cmd_data = 8'h00;
      @(negedge clk);
      cmd_op = 3'd7;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 3'd0;
      check("R9 read ignored", 32'(rd_valid), 32'd0);
      while (busy) @(negedge clk);
      check("R9 search result", 32'(resp_vec), 32'h02);
      issue(3'd5, 3'd0, 8'h00, cyc);
      check("R9 store ignored", 32'(resp_vec), 32'h02);
      issue(3'd7, 3'd0, 8'h00, cyc);
      check("R9 word kept", 32'(rd_word), 32'hA5);
      check("R5 index", 32'(rd_index), 32'd1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule